// File: doc/BRIEF.md
# Extended Program-Memory Byte Loader

This execution unit serves a small 8-bit CPU core. It carries out the three variants of the extended load-from-program-memory instruction. The core hands it a 16-bit opcode together with a start strobe. In the same cycle the core also presents the 16-bit pointer held in general registers r30 (low byte) and r31 (high byte), and the 8-bit page-extension register.

The unit checks the opcode and latches its operands. It then forms a wide byte address, with the low bits of the page register above the pointer. One byte is read through a synchronous program-memory port that has a latency of one cycle. In the final cycle the unit writes that byte to a general register. The post-increment variant also writes back the incremented pointer in that cycle. When the pointer rolls over, it also writes back a page register that has been advanced and wrapped.

When the opcode matches no variant, the unit raises a one-cycle rejection flag and writes nothing. Each accepted instruction takes three cycles and ends with a single pulse that advances the program counter by one word.

Top module: `pgm_byte_loader`

## Requirements
- R1: Opcode 0x95D8 (implied variant) loads the byte into register index 0. It performs no pointer or page write.
- R2: An opcode whose bits under mask 0xFE0F equal 0x9006 (register variant) loads the byte into the register whose index is opcode bits [8:4]. It performs no pointer or page write.
- R3: An opcode whose bits under mask 0xFE0F equal 0x9007 (post-increment variant) loads the byte into the register at opcode bits [8:4]. In the same cycle it writes back pointer+1 modulo 2^16.
- R4: In the first cycle after the start edge, exactly one program-memory read is issued. Its byte address is {page[PG_W-1:0], pointer}, where PG_W = clog2(NUM_PAGES). The byte returned in the next cycle is the byte written to the register.
- R5: In the post-increment variant, a page write happens only when the pointer was 0xFFFF. The value written is page+1, or 0 when page+1 reaches NUM_PAGES. With the default of 2 pages, page 1 becomes 0.
- R6: The register write, any pointer or page write, done and the program-counter advance pulse all appear together in the third cycle after the start edge, for exactly one cycle.
- R7: A start with an opcode that matches no variant raises illegal for exactly the next cycle. It issues no read and no write.
- R8: A start presented while an instruction is in progress is ignored. This holds whether its opcode is legal or not.
- R9: While reset is asserted, every strobe output (read, writes, done, advance, illegal) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an instruction with the presented opcode and operands |
| opcode | input | 16 | Instruction word |
| zptr_i | input | 16 | Current pointer value from the r31:r30 pair |
| page_i | input | 8 | Current page-extension register value |
| pm_rd_en | output | 1 | Program-memory read strobe |
| pm_addr | output | 16+PG_W | Program-memory byte address |
| pm_rdata | input | 8 | Program-memory byte, valid one cycle after the strobe |
| rf_we | output | 1 | General-register write enable |
| rf_waddr | output | 5 | General-register write index |
| rf_wdata | output | 8 | General-register write data |
| zptr_we | output | 1 | Pointer pair write enable |
| zptr_wdata | output | 16 | Incremented pointer value |
| page_we | output | 1 | Page-extension register write enable |
| page_wdata | output | 8 | Advanced and wrapped page value |
| pc_inc | output | 1 | Advance the program counter by one word |
| done | output | 1 | Instruction complete |
| illegal | output | 1 | Opcode matched no variant |

## Verification
A wrong state in the sequencer shows up at once as a misplaced read strobe or done pulse. The bench checks the cycle after every start, so the fault is caught within three cycles. A latched operand or variant that has been corrupted can only be seen in the write-back cycle. That is where the address the read strobe carried, the destination index, the write-back data and the pointer and page enables are each compared against the reference model. The pointer-carry and page-wrap path is driven across both page values and at the 0xFFFF boundary, because an error there changes only page_we and page_wdata.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
  typedef enum logic [1:0] {FORM_IMPL, FORM_REG, FORM_INC, FORM_NONE} form_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_READ, ST_WB} state_e;

  localparam logic [15:0] OPC_IMPLIED = 16'h95D8;
  localparam logic [15:0] OPC_MASK    = 16'hFE0F;
  localparam logic [15:0] OPC_REGFORM = 16'h9006;
  localparam logic [15:0] OPC_INCFORM = 16'h9007;
endpackage

// File: rtl/pbl_decode.sv
module pbl_decode
  import pbl_pkg::*;
(
  input  logic [15:0] opcode,
  output form_e       form,
  output logic [4:0]  dest,
  output logic        legal
);
  always_comb begin
    form = FORM_NONE;
    if (opcode == OPC_IMPLIED)
      form = FORM_IMPL;
    else if ((opcode & OPC_MASK) == OPC_REGFORM)
      form = FORM_REG;
    else if ((opcode & OPC_MASK) == OPC_INCFORM)
      form = FORM_INC;
  end

  assign dest  = (form == FORM_IMPL) ? 5'd0 : opcode[8:4];
  assign legal = (form != FORM_NONE);
endmodule

// File: rtl/pbl_ptr_math.sv
module pbl_ptr_math #(
  parameter int NUM_PAGES = 2
) (
  input  logic [15:0] zptr,
  input  logic [7:0]  page,
  output logic [15:0] zptr_next,
  output logic        carry,
  output logic [7:0]  page_next
);
  localparam logic [7:0] LAST_PAGE = 8'(NUM_PAGES - 1);

  assign zptr_next = zptr + 16'd1;
  assign carry     = &zptr;
  assign page_next = (page >= LAST_PAGE) ? 8'd0 : page + 8'd1;
endmodule

// File: rtl/pbl_fsm.sv
module pbl_fsm
  import pbl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   legal,
  output state_e state,
  output logic   accept,
  output logic   reject
);
  state_e state_q, state_d;

  assign accept = (state_q == ST_IDLE) && start && legal;
  assign reject = (state_q == ST_IDLE) && start && !legal;
  assign state  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_READ;
      ST_READ: state_d = ST_WB;
      ST_WB:   state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pgm_byte_loader.sv
module pgm_byte_loader
  import pbl_pkg::*;
#(
  parameter  int NUM_PAGES = 2,
  localparam int PG_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int ADDR_W    = 16 + PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       opcode,
  input  logic [15:0]       zptr_i,
  input  logic [7:0]        page_i,
  output logic              pm_rd_en,
  output logic [ADDR_W-1:0] pm_addr,
  input  logic [7:0]        pm_rdata,
  output logic              rf_we,
  output logic [4:0]        rf_waddr,
  output logic [7:0]        rf_wdata,
  output logic              zptr_we,
  output logic [15:0]       zptr_wdata,
  output logic              page_we,
  output logic [7:0]        page_wdata,
  output logic              pc_inc,
  output logic              done,
  output logic              illegal
);
  // reset: asserts asynchronously, releases on a clock edge
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  form_e      dec_form;
  logic [4:0] dec_dest;
  logic       dec_legal;

  pbl_decode u_dec (
    .opcode (opcode),
    .form   (dec_form),
    .dest   (dec_dest),
    .legal  (dec_legal)
  );

  state_e state;
  logic   accept, reject;

  pbl_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .start  (start),
    .legal  (dec_legal),
    .state  (state),
    .accept (accept),
    .reject (reject)
  );

  form_e       form_q;
  logic [4:0]  dest_q;
  logic [15:0] zptr_q;
  logic [7:0]  page_q;
  logic [7:0]  byte_q;
  logic        ill_q;
  logic        capture_en;

  assign capture_en = (state == ST_READ);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      form_q <= FORM_NONE;
      dest_q <= 5'd0;
      zptr_q <= 16'd0;
      page_q <= 8'd0;
    end else if (accept) begin
      form_q <= dec_form;
      dest_q <= dec_dest;
      zptr_q <= zptr_i;
      page_q <= page_i;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     byte_q <= 8'd0;
    else if (capture_en) byte_q <= pm_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ill_q <= 1'b0;
    else             ill_q <= reject;
  end

  logic [15:0] zptr_next;
  logic        zptr_carry;
  logic [7:0]  page_next;

  pbl_ptr_math #(.NUM_PAGES(NUM_PAGES)) u_math (
    .zptr      (zptr_q),
    .page      (page_q),
    .zptr_next (zptr_next),
    .carry     (zptr_carry),
    .page_next (page_next)
  );

  logic in_wb;
  assign in_wb = (state == ST_WB);

  assign pm_rd_en   = (state == ST_ADDR);
  assign pm_addr    = {page_q[PG_W-1:0], zptr_q};
  assign rf_we      = in_wb;
  assign rf_waddr   = dest_q;
  assign rf_wdata   = byte_q;
  assign zptr_we    = in_wb && (form_q == FORM_INC);
  assign zptr_wdata = zptr_next;
  assign page_we    = zptr_we && zptr_carry;
  assign page_wdata = page_next;
  assign pc_inc     = in_wb;
  assign done       = in_wb;
  assign illegal    = ill_q;
endmodule

// File: rtl/pbl_checker.sv
module pbl_checker #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pm_rd_en,
  input logic [ADDR_W-1:0] pm_addr,
  input logic              rf_we,
  input logic              zptr_we,
  input logic [15:0]       zptr_wdata,
  input logic              page_we,
  input logic              pc_inc,
  input logic              done,
  input logic              illegal
);
  p_done_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pm_rd_en, 2));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_advance_with_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |-> (rf_we && done));

  p_ptr_plus_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zptr_we |-> (zptr_wdata == $past(pm_addr[15:0], 2) + 16'd1));

  p_page_on_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |-> ($past(pm_addr[15:0], 2) == 16'hFFFF));

  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!rf_we && !zptr_we && !page_we && !pm_rd_en));

  p_illegal_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal);

  p_strobes_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pm_rd_en, done, illegal}));
endmodule

bind pgm_byte_loader pbl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .pm_rd_en   (pm_rd_en),
  .pm_addr    (pm_addr),
  .rf_we      (rf_we),
  .zptr_we    (zptr_we),
  .zptr_wdata (zptr_wdata),
  .page_we    (page_we),
  .pc_inc     (pc_inc),
  .done       (done),
  .illegal    (illegal)
);

// File: tb/sim_pgm_byte_loader.sv
module sim_pgm_byte_loader;
  localparam int NUM_PAGES = 2;
  localparam int ADDR_W    = 17;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [15:0]       opcode;
  logic [15:0]       zptr_i;
  logic [7:0]        page_i;
  logic              pm_rd_en;
  logic [ADDR_W-1:0] pm_addr;
  logic [7:0]        pm_rdata;
  logic              rf_we;
  logic [4:0]        rf_waddr;
  logic [7:0]        rf_wdata;
  logic              zptr_we;
  logic [15:0]       zptr_wdata;
  logic              page_we;
  logic [7:0]        page_wdata;
  logic              pc_inc;
  logic              done;
  logic              illegal;

  always #4 clk = ~clk;

  pgm_byte_loader #(.NUM_PAGES(NUM_PAGES)) u0 (.*);

  function automatic logic [7:0] mem_f(logic [ADDR_W-1:0] a);
    return a[7:0] ^ {a[15:12], a[11:8]} ^ {7'h2A, a[16]} ^ 8'h5C;
  endfunction

  always @(posedge clk) if (pm_rd_en) pm_rdata <= mem_f(pm_addr);

  int checks = 0;
  int errors = 0;
  bit chk_on = 1'b0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          phase = 0;
  bit          e_ill = 0;
  int          e_form = 0;   // 1 implied, 2 register, 3 post-increment
  int          e_dest = 0;
  int          e_z = 0;
  int          e_page = 0;
  logic [ADDR_W-1:0] e_addr;

  always @(posedge clk) begin
    e_ill = 0;
    if (!rst_n) phase = 0;
    else begin
      case (phase)
        0: if (start) begin
             if (opcode == 16'h95D8) e_form = 1;
             else if ((opcode & 16'hFE0F) == 16'h9006) e_form = 2;
             else if ((opcode & 16'hFE0F) == 16'h9007) e_form = 3;
             else e_form = 0;
             if (e_form == 0) e_ill = 1;
             else begin
               phase  = 1;
               e_dest = (e_form == 1) ? 0 : int'(opcode[8:4]);
               e_z    = int'(zptr_i);
               e_page = int'(page_i);
               e_addr = ADDR_W'((e_page % NUM_PAGES) * 65536 + e_z);
             end
           end
        1: phase = 2;
        2: phase = 3;
        default: phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (chk_on) begin
      bit wb, zw, pw;
      string rt;
      wb = (phase == 3);
      zw = wb && (e_form == 3);
      pw = zw && (e_z == 16'hFFFF);
      rt = (e_form == 1) ? "R1" : (e_form == 2) ? "R2" : "R3";
      if (!rst_n) begin
        check({pm_rd_en, rf_we, zptr_we, page_we, pc_inc, done, illegal} == 7'd0,
              "R9 reset strobes", {pm_rd_en, rf_we, zptr_we, page_we, pc_inc, done, illegal}, 0);
      end else begin
        check(pm_rd_en === (phase == 1), "R4 read strobe", pm_rd_en, phase == 1);
        if (phase == 1) check(pm_addr === e_addr, "R4 address", pm_addr, e_addr);
        check(done === wb, "R6 done", done, wb);
        check(pc_inc === wb, "R6 pc advance", pc_inc, wb);
        check(rf_we === wb, "R6 register write", rf_we, wb);
        check(illegal === e_ill, "R7 R8 illegal", illegal, e_ill);
        check(zptr_we === zw, {rt, " pointer write enable"}, zptr_we, zw);
        check(page_we === pw, "R5 page write enable", page_we, pw);
        if (wb) begin
          check(rf_waddr === 5'(e_dest), {rt, " destination"}, rf_waddr, e_dest);
          check(rf_wdata === mem_f(e_addr), "R4 loaded byte", rf_wdata, mem_f(e_addr));
        end
        if (zw) check(zptr_wdata === 16'(e_z + 1), "R3 pointer value", zptr_wdata, 16'(e_z + 1));
        if (pw) check(page_wdata === 8'((e_page + 1) % NUM_PAGES), "R5 page wrap",
                      page_wdata, (e_page + 1) % NUM_PAGES);
      end
    end
  end

  task automatic issue(logic [15:0] op, logic [15:0] z, logic [7:0] pg);
    @(negedge clk);
    start = 1'b1; opcode = op; zptr_i = z; page_i = pg;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = 16'h0; zptr_i = 16'h0; page_i = 8'h0;
    @(negedge clk);
    chk_on = 1'b1;               // R9 reset state checked while rst_n is low
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    issue(16'h95D8, 16'h0050, 8'h01);   // R1 implied
    issue(16'h9056, 16'h0011, 8'h00);   // R2 r5
    issue(16'h91F6, 16'hABCD, 8'h01);   // R2 r31
    issue(16'h9067, 16'hFFFF, 8'h00);   // R3 R5 carry into page 1
    issue(16'h9067, 16'hFFFF, 8'h01);   // R5 wrap to page 0
    issue(16'h91F7, 16'h1234, 8'h01);   // R3 no carry
    issue(16'h0000, 16'h1111, 8'h00);   // R7
    issue(16'h95D9, 16'h2222, 8'h00);   // R7 near implied
    issue(16'h9008, 16'h3333, 8'h01);   // R7 near register form

    // R8: starts during a busy instruction are ignored
    @(negedge clk);
    start = 1'b1; opcode = 16'h9037; zptr_i = 16'h00FF; page_i = 8'h01;
    @(negedge clk); opcode = 16'h0000;              // illegal while busy
    @(negedge clk); opcode = 16'h95D8; zptr_i = 16'h7777;  // legal while busy
    @(negedge clk); opcode = 16'h9006;              // during write-back
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);

    // back-to-back
    @(negedge clk);
    start = 1'b1; opcode = 16'h9017; zptr_i = 16'hFFFE; page_i = 8'h00;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1; opcode = 16'h9017; zptr_i = 16'hFFFF; page_i = 8'h00;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule